// File: doc/BRIEF.md
# Calendar time counter with user-visible double buffer

This block keeps the time of day and the calendar: seconds, minutes, hours, day of the week, day of the month, month and a two-digit year. A one-cycle strobe, usually once per second, advances the time by one second. Months have their proper lengths, February gains a day in leap years, and an optional daylight-saving rule skips one hour in spring and repeats one hour in autumn. The time is counted in canonical binary form inside the block. On the way out it is encoded as binary or BCD, and the hour is shown in 24-hour or in 12-hour form with a PM flag.

There are two copies of the time. The internal working copy counts. The user copy is what the ten output bytes show. While the freeze control is high, the user copy holds still and takes host writes, but the internal copy keeps counting. When the freeze is released, one of two things happens. If the host wrote a time byte during the freeze, the internal copy is loaded from the user copy. If it did not, the user copy picks up the time that was counted in the background. Three alarm bytes share the address space. The host owns them and counting never touches them.

Top module: `rtc_cal_top`

## Requirements
- R1: After reset, with 24-hour BCD mode selected, the outputs read seconds 0x00, minutes 0x00, hour 0x00, weekday 0x01, date 0x01, month 0x01, year 0x00, and all three alarm bytes read 0x00.
- R2: When the strobe is high in a cycle, the time advances by exactly one second at that clock edge. Seconds carry into minutes at 59, and minutes carry into hours at 59. When the strobe is low, nothing changes.
- R3: `bin_mode_i`=1 shows every time byte in plain binary (59 reads as 0x3B). `bin_mode_i`=0 shows it in BCD (59 reads as 0x59).
- R4: `h24_mode_i`=0 selects 12-hour form. The hour byte holds 1..12 in bits 6:0, and bit 7 set means PM. 11 AM is followed by 12 PM, 11 PM is followed by 12 AM, and the day advances at that step. `h24_mode_i`=1 selects hours 0..23.
- R5: At midnight the weekday steps from 7 back to 1 (Sunday is 1). The date wraps to 1 after day 30 in April, June, September and November, and after day 31 in the other long months. The month wraps from 12 to 1, and at that wrap the year increments.
- R6: February ends after day 29 when the year is divisible by 4 and after day 28 otherwise. The year wraps from 99 to 0.
- R7: With `dst_en_i`=1, on a Sunday in April whose date is 1..7, 01:59:59 is followed by 03:00:00. With `dst_en_i`=0 it is followed by 02:00:00.
- R8: With `dst_en_i`=1, on a Sunday in October whose date is 25..31, the first 01:59:59 is followed by 01:00:00. The second 01:59:59 that night is followed by 02:00:00. The flag that blocks a second repeat clears at the next midnight, and also when the time is loaded.
- R9: While `set_i`=1, the output time bytes hold their values across strobes, while the internal copy keeps counting. A host write while `set_i`=1 is visible on the outputs after that one clock edge.
- R10: At the edge where `set_i` falls, the internal copy is loaded from the user copy if a time byte was written while `set_i` was high, and the load takes precedence over a strobe in that same cycle. If no time byte was written, the outputs show the time that was counted during the freeze.
- R11: The address map is 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hour, 5 hour alarm, 6 weekday, 7 date, 8 month, 9 year. Writes to time bytes while `set_i`=0, and writes to addresses 10..15, have no effect. Alarm bytes take writes at any time and are never changed by counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second advance strobe, one cycle wide |
| set_i | input | 1 | Freeze user copy and accept host time writes |
| bin_mode_i | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| h24_mode_i | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| dst_en_i | input | 1 | Enable daylight-saving skip and repeat |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 4 | Host write address |
| wr_data_i | input | 8 | Host write data, in the current encoding |
| sec_o | output | 8 | Seconds |
| sec_alm_o | output | 8 | Seconds alarm |
| min_o | output | 8 | Minutes |
| min_alm_o | output | 8 | Minutes alarm |
| hour_o | output | 8 | Hour |
| hour_alm_o | output | 8 | Hour alarm |
| wday_o | output | 8 | Day of week, 1..7 |
| mday_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Two-digit year |

## Verification
Every result appears at the first clock edge that samples its cause: a strobe, a host write or the falling edge of `set_i`. This is because the user copy is loaded from the next-state value of the internal copy rather than from the registered one. The bench drives each stimulus on a falling edge, holds it for one cycle and compares the outputs on the next falling edge, so each check lands exactly one edge after its cause. The cases where a result must not appear (frozen outputs, ignored writes, untouched alarms) are checked in the same way. The internal count during a freeze is observed at the release edge.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  // Canonical counting form: plain binary, hour 0..23.
  typedef struct packed {
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hour;
    logic [2:0] dow;
    logic [4:0] date;
    logic [3:0] month;
    logic [6:0] year;
  } cal_t;

  localparam int NBYTES = 10;
  localparam cal_t CAL_RESET = '{sec: 6'd0, min: 6'd0, hour: 5'd0, dow: 3'd1,
                                 date: 5'd1, month: 4'd1, year: 7'd0};

  function automatic logic is_leap(input logic [6:0] yr);
    return (yr[1:0] == 2'b00);
  endfunction

  function automatic logic [4:0] days_in_month(input logic [3:0] mo, input logic [6:0] yr);
    case (mo)
      4'd2:                      return is_leap(yr) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

  function automatic logic [7:0] enc_val(input logic [6:0] v, input logic bin);
    logic [6:0] tens, ones;
    tens = v / 7'd10;
    ones = v % 7'd10;
    return bin ? {1'b0, v} : {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [6:0] dec_val(input logic [7:0] b, input logic bin);
    return bin ? b[6:0] : (7'(b[7:4]) * 7'd10 + 7'(b[3:0]));
  endfunction

  function automatic logic [7:0] enc_hour(input logic [4:0] h, input logic bin, input logic h24);
    logic [4:0] h12;
    logic [7:0] t;
    if (h24) return enc_val({2'b00, h}, bin);
    h12 = h % 5'd12;
    if (h12 == 5'd0) h12 = 5'd12;
    t = enc_val({2'b00, h12}, bin);
    return {(h >= 5'd12), t[6:0]};
  endfunction

  function automatic logic [4:0] dec_hour(input logic [7:0] b, input logic bin, input logic h24);
    logic [6:0] v;
    if (h24) begin
      v = dec_val(b, bin);
      return v[4:0];
    end
    v = dec_val({1'b0, b[6:0]}, bin);
    if (v == 7'd12) return b[7] ? 5'd12 : 5'd0;
    return b[7] ? (v[4:0] + 5'd12) : v[4:0];
  endfunction

endpackage

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
  import rtc_cal_pkg::*;
#(
  parameter int YEAR_MAX = 99,
  parameter int SPRING_LAST_DATE = 7,
  parameter int AUTUMN_FIRST_DATE = 25
) (
  input  cal_t cur_i,
  input  logic rep_i,
  input  logic dst_en_i,
  output cal_t nxt_o,
  output logic rep_o,
  output logic ev_day_wrap_o,
  output logic ev_dst_skip_o,
  output logic ev_dst_repeat_o
);
  localparam logic [6:0] YMAX = 7'(YEAR_MAX);

  logic sec_w, min_w, hr_w, date_w, mon_w;
  logic sunday, spring, autumn;
  logic [4:0] dim;

  always_comb begin
    dim    = days_in_month(cur_i.month, cur_i.year);
    sec_w  = (cur_i.sec == 6'd59);
    min_w  = sec_w && (cur_i.min == 6'd59);
    hr_w   = min_w && (cur_i.hour == 5'd23);
    date_w = hr_w && (cur_i.date >= dim);
    mon_w  = date_w && (cur_i.month == 4'd12);
    sunday = (cur_i.dow == 3'd1);
    spring = dst_en_i && sunday && (cur_i.month == 4'd4) &&
             (cur_i.date <= 5'(SPRING_LAST_DATE)) && (cur_i.hour == 5'd1) && min_w;
    autumn = dst_en_i && sunday && (cur_i.month == 4'd10) &&
             (cur_i.date >= 5'(AUTUMN_FIRST_DATE)) && (cur_i.hour == 5'd1) && min_w && !rep_i;

    nxt_o = cur_i;
    rep_o = rep_i;
    nxt_o.sec = sec_w ? 6'd0 : cur_i.sec + 6'd1;
    if (sec_w) nxt_o.min = min_w ? 6'd0 : cur_i.min + 6'd1;
    if (min_w) begin
      if (spring)      nxt_o.hour = 5'd3;
      else if (autumn) begin
        nxt_o.hour = 5'd1;
        rep_o      = 1'b1;
      end
      else             nxt_o.hour = hr_w ? 5'd0 : cur_i.hour + 5'd1;
    end
    if (hr_w) begin
      rep_o      = 1'b0;
      nxt_o.dow  = (cur_i.dow >= 3'd7) ? 3'd1 : cur_i.dow + 3'd1;
      nxt_o.date = date_w ? 5'd1 : cur_i.date + 5'd1;
    end
    if (date_w) nxt_o.month = mon_w ? 4'd1 : cur_i.month + 4'd1;
    if (mon_w)  nxt_o.year  = (cur_i.year >= YMAX) ? 7'd0 : cur_i.year + 7'd1;

    ev_day_wrap_o   = hr_w;
    ev_dst_skip_o   = spring;
    ev_dst_repeat_o = autumn;
  end
endmodule

// File: rtl/rtc_cal_core.sv
module rtc_cal_core
  import rtc_cal_pkg::*;
#(
  parameter int YEAR_MAX = 99
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic dst_en_i,
  input  logic load_i,
  input  cal_t load_val_i,
  output cal_t cur_d_o
);
  cal_t cur_q, step_nxt;
  logic rep_q, rep_d, step_rep;
  logic ev_day_wrap, ev_dst_skip, ev_dst_repeat;

  rtc_cal_step #(.YEAR_MAX(YEAR_MAX)) u_step (
    .cur_i           (cur_q),
    .rep_i           (rep_q),
    .dst_en_i        (dst_en_i),
    .nxt_o           (step_nxt),
    .rep_o           (step_rep),
    .ev_day_wrap_o   (ev_day_wrap),
    .ev_dst_skip_o   (ev_dst_skip),
    .ev_dst_repeat_o (ev_dst_repeat)
  );

  always_comb begin
    cur_d_o = cur_q;
    rep_d   = rep_q;
    if (load_i) begin
      cur_d_o = load_val_i;
      rep_d   = 1'b0;
    end else if (tick_i) begin
      cur_d_o = step_nxt;
      rep_d   = step_rep;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= CAL_RESET;
      rep_q <= 1'b0;
    end else begin
      cur_q <= cur_d_o;
      rep_q <= rep_d;
    end
  end

  // R2
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && cur_q.sec < 6'd59) |=> (cur_q.sec == $past(cur_q.sec) + 6'd1));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(cur_q) && $stable(rep_q));
  // R7
  spring_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && ev_dst_skip) |=> (cur_q.hour == 5'd3 && cur_q.min == 6'd0));
  // R8
  autumn_rep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && ev_dst_repeat) |=> (rep_q && cur_q.hour == 5'd1));
  // R8
  rep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && ev_day_wrap) |=> !rep_q);
endmodule

// File: rtl/rtc_cal_user.sv
module rtc_cal_user
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic              bin_i,
  input  logic              h24_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  cal_t              cur_d_i,
  output logic              load_o,
  output cal_t              load_val_o,
  output logic [NBYTES-1:0][7:0] bytes_o
);
  logic [NBYTES-1:0][7:0] mirror;
  logic [NBYTES-1:0]      hit;
  logic                   set_q, dirty_q, time_hit;

  always_comb begin
    mirror    = '0;
    mirror[0] = enc_val({1'b0, cur_d_i.sec}, bin_i);
    mirror[2] = enc_val({1'b0, cur_d_i.min}, bin_i);
    mirror[4] = enc_hour(cur_d_i.hour, bin_i, h24_i);
    mirror[6] = enc_val({4'd0, cur_d_i.dow}, bin_i);
    mirror[7] = enc_val({2'd0, cur_d_i.date}, bin_i);
    mirror[8] = enc_val({3'd0, cur_d_i.month}, bin_i);
    mirror[9] = enc_val(cur_d_i.year, bin_i);
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    localparam bit IS_ALM = (i == 1) || (i == 3) || (i == 5);
    localparam logic [7:0] RST_V = (i == 6 || i == 7 || i == 8) ? 8'h01 : 8'h00;
    assign hit[i] = wr_en_i && (wr_addr_i == ADDR_W'(i));
    if (IS_ALM) begin : g_alm
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bytes_o[i] <= RST_V;
        else if (hit[i]) bytes_o[i] <= wr_data_i;
      end
    end else begin : g_time
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bytes_o[i] <= RST_V;
        else if (set_i) begin
          if (hit[i])    bytes_o[i] <= wr_data_i;
        end else         bytes_o[i] <= mirror[i];
      end
    end
  end

  assign time_hit = |(hit & 10'b11_1101_0101);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q   <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      set_q   <= set_i;
      dirty_q <= set_i && (dirty_q || time_hit);
    end
  end

  assign load_o = set_q && !set_i && dirty_q;

  always_comb begin
    load_val_o.sec   = dec_val(bytes_o[0], bin_i)[5:0];
    load_val_o.min   = dec_val(bytes_o[2], bin_i)[5:0];
    load_val_o.hour  = dec_hour(bytes_o[4], bin_i, h24_i);
    load_val_o.dow   = dec_val(bytes_o[6], bin_i)[2:0];
    load_val_o.date  = dec_val(bytes_o[7], bin_i)[4:0];
    load_val_o.month = dec_val(bytes_o[8], bin_i)[3:0];
    load_val_o.year  = dec_val(bytes_o[9], bin_i);
  end

  // R9
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !wr_en_i) |=> $stable({bytes_o[9:6], bytes_o[4], bytes_o[2], bytes_o[0]}));
  // R11
  alarm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit[1] || hit[3] || hit[5]) |=> $stable({bytes_o[5], bytes_o[3], bytes_o[1]}));
  // R10
  load_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o);
endmodule

// File: rtl/rtc_cal_top.sv
module rtc_cal_top
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int YEAR_MAX = 99
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              set_i,
  input  logic              bin_mode_i,
  input  logic              h24_mode_i,
  input  logic              dst_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        sec_o,
  output logic [7:0]        sec_alm_o,
  output logic [7:0]        min_o,
  output logic [7:0]        min_alm_o,
  output logic [7:0]        hour_o,
  output logic [7:0]        hour_alm_o,
  output logic [7:0]        wday_o,
  output logic [7:0]        mday_o,
  output logic [7:0]        month_o,
  output logic [7:0]        year_o
);
  cal_t cur_d, load_val;
  logic load;
  logic [NBYTES-1:0][7:0] bytes;

  rtc_cal_core #(.YEAR_MAX(YEAR_MAX)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .dst_en_i   (dst_en_i),
    .load_i     (load),
    .load_val_i (load_val),
    .cur_d_o    (cur_d)
  );

  rtc_cal_user #(.ADDR_W(ADDR_W)) u_user (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (set_i),
    .bin_i      (bin_mode_i),
    .h24_i      (h24_mode_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .cur_d_i    (cur_d),
    .load_o     (load),
    .load_val_o (load_val),
    .bytes_o    (bytes)
  );

  assign sec_o      = bytes[0];
  assign sec_alm_o  = bytes[1];
  assign min_o      = bytes[2];
  assign min_alm_o  = bytes[3];
  assign hour_o     = bytes[4];
  assign hour_alm_o = bytes[5];
  assign wday_o     = bytes[6];
  assign mday_o     = bytes[7];
  assign month_o    = bytes[8];
  assign year_o     = bytes[9];
endmodule

// File: tb/rtc_cal_top_tb_top.sv
module rtc_cal_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, set = 1'b0, bin = 1'b0, h24 = 1'b1, dst = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = 4'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] sec_o, sec_alm_o, min_o, min_alm_o, hour_o, hour_alm_o;
  logic [7:0] wday_o, mday_o, month_o, year_o;
  int errors = 0, checks = 0, cycles = 0;

  always #10 clk = ~clk;

  rtc_cal_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .set_i(set), .bin_mode_i(bin),
    .h24_mode_i(h24), .dst_en_i(dst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .sec_o(sec_o), .sec_alm_o(sec_alm_o), .min_o(min_o),
    .min_alm_o(min_alm_o), .hour_o(hour_o), .hour_alm_o(hour_alm_o),
    .wday_o(wday_o), .mday_o(mday_o), .month_o(month_o), .year_o(year_o)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_time(input string req, input logic [7:0] h, m, s);
    chk(req, "hour", hour_o, h);
    chk(req, "min", min_o, m);
    chk(req, "sec", sec_o, s);
  endtask

  task automatic chk_date(input string req, input logic [7:0] dw, dt, mo, yr);
    chk(req, "wday", wday_o, dw);
    chk(req, "mday", mday_o, dt);
    chk(req, "month", month_o, mo);
    chk(req, "year", year_o, yr);
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick1();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load_time(input logic [7:0] s, m, h, dw, dt, mo, yr);
    set = 1'b1;
    wr(4'd0, s); wr(4'd2, m); wr(4'd4, h); wr(4'd6, dw);
    wr(4'd7, dt); wr(4'd8, mo); wr(4'd9, yr);
    set = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk_time("R1", 8'h00, 8'h00, 8'h00);
    chk_date("R1", 8'h01, 8'h01, 8'h01, 8'h00);
    chk("R1", "alarms", sec_alm_o | min_alm_o | hour_alm_o, 8'h00);
  endtask

  task automatic t_count_bcd();
    bin = 1'b0; h24 = 1'b1;
    load_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    chk_time("R10", 8'h23, 8'h59, 8'h58);
    idle(3);
    chk("R2", "no tick hold", sec_o, 8'h58);
    tick1();
    chk("R3", "bcd sec 59", sec_o, 8'h59);
    tick1();
    chk_time("R5", 8'h00, 8'h00, 8'h00);
    chk_date("R5", 8'h01, 8'h01, 8'h01, 8'h00);
    chk("R6", "year 99 wraps", year_o, 8'h00);
  endtask

  task automatic t_count_bin();
    bin = 1'b1; h24 = 1'b1;
    load_time(8'h3A, 8'h0A, 8'h05, 8'h03, 8'h0A, 8'h03, 8'h0F);
    tick1();
    chk("R3", "binary sec 59", sec_o, 8'h3B);
    tick1();
    chk_time("R2", 8'h05, 8'h0B, 8'h00);
    load_time(8'h3B, 8'h3B, 8'h0E, 8'h03, 8'h0A, 8'h03, 8'h0F);
    tick1();
    chk_time("R2", 8'h0F, 8'h00, 8'h00);
  endtask

  task automatic t_months();
    bin = 1'b0; h24 = 1'b1;
    load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
    tick1();
    chk("R6", "feb non-leap", mday_o, 8'h01);
    chk("R6", "feb non-leap month", month_o, 8'h03);
    load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
    tick1();
    chk("R6", "feb leap date", mday_o, 8'h29);
    chk("R6", "feb leap month", month_o, 8'h02);
    load_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h04, 8'h24);
    tick1();
    chk_date("R5", 8'h06, 8'h01, 8'h05, 8'h24);
    load_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h05, 8'h24);
    tick1();
    chk("R5", "may 31 exists", mday_o, 8'h31);
  endtask

  task automatic t_12h();
    bin = 1'b0; h24 = 1'b0;
    load_time(8'h59, 8'h59, 8'h11, 8'h02, 8'h05, 8'h06, 8'h10);
    tick1();
    chk("R4", "11am->12pm bcd", hour_o, 8'h92);
    load_time(8'h59, 8'h59, 8'h91, 8'h02, 8'h05, 8'h06, 8'h10);
    tick1();
    chk("R4", "11pm->12am bcd", hour_o, 8'h12);
    chk("R4", "date advances", mday_o, 8'h06);
    bin = 1'b1;
    load_time(8'h3B, 8'h3B, 8'h0B, 8'h02, 8'h05, 8'h06, 8'h0A);
    tick1();
    chk("R4", "11am->12pm bin", hour_o, 8'h8C);
    tick1();
    chk("R4", "12pm holds", hour_o, 8'h8C);
    h24 = 1'b1;
    @(negedge clk);
    chk("R4", "24h view of 12pm", hour_o, 8'h0C);
  endtask

  task automatic t_dst_spring();
    bin = 1'b0; h24 = 1'b1; dst = 1'b1;
    load_time(8'h59, 8'h59, 8'h01, 8'h01, 8'h03, 8'h04, 8'h22);
    tick1();
    chk_time("R7", 8'h03, 8'h00, 8'h00);
    dst = 1'b0;
    load_time(8'h59, 8'h59, 8'h01, 8'h01, 8'h03, 8'h04, 8'h22);
    tick1();
    chk_time("R7", 8'h02, 8'h00, 8'h00);
    dst = 1'b1;
    load_time(8'h59, 8'h59, 8'h01, 8'h01, 8'h10, 8'h04, 8'h22);
    tick1();
    chk("R7", "second sunday no skip", hour_o, 8'h02);
  endtask

  task automatic t_dst_autumn();
    bin = 1'b0; h24 = 1'b1; dst = 1'b1;
    load_time(8'h59, 8'h59, 8'h01, 8'h01, 8'h28, 8'h10, 8'h22);
    tick1();
    chk_time("R8", 8'h01, 8'h00, 8'h00);
    for (int i = 0; i < 3599; i++) tick1();
    chk_time("R8", 8'h01, 8'h59, 8'h59);
    tick1();
    chk_time("R8", 8'h02, 8'h00, 8'h00);
    dst = 1'b0;
  endtask

  task automatic t_freeze();
    bin = 1'b0; h24 = 1'b1;
    load_time(8'h00, 8'h00, 8'h10, 8'h03, 8'h15, 8'h07, 8'h20);
    set = 1'b1;
    tick1(); tick1(); tick1();
    chk_time("R9", 8'h10, 8'h00, 8'h00);
    set = 1'b0;
    @(negedge clk);
    chk("R9", "internal kept counting", sec_o, 8'h03);
    chk("R10", "no write keeps count", hour_o, 8'h10);
    set = 1'b1;
    wr(4'd0, 8'h30);
    chk("R9", "write visible in freeze", sec_o, 8'h30);
    tick1();
    chk("R9", "frozen after write", sec_o, 8'h30);
    set = 1'b0; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk("R10", "load wins over tick", sec_o, 8'h30);
    tick1();
    chk("R10", "count from loaded", sec_o, 8'h31);
  endtask

  task automatic t_ignored();
    wr(4'd0, 8'h45);
    chk("R11", "sec write with set low", sec_o, 8'h31);
    wr(4'd1, 8'h12); wr(4'd3, 8'h34); wr(4'd5, 8'h56);
    chk("R11", "sec alarm", sec_alm_o, 8'h12);
    chk("R11", "min alarm", min_alm_o, 8'h34);
    chk("R11", "hour alarm", hour_alm_o, 8'h56);
    set = 1'b1;
    wr(4'd12, 8'h77);
    set = 1'b0;
    @(negedge clk);
    chk("R11", "addr 12 ignored sec", sec_o, 8'h31);
    chk("R11", "addr 12 ignored year", year_o, 8'h20);
    tick1();
    chk("R11", "alarm unchanged by tick", sec_alm_o, 8'h12);
    chk("R11", "hour alarm unchanged", hour_alm_o, 8'h56);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
      end
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count_bcd();
    t_count_bin();
    t_months();
    t_12h();
    t_dst_spring();
    t_dst_autumn();
    t_freeze();
    t_ignored();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule